// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block is an SPI master that loads a bitstream into a target FPGA through the target's slave configuration port. After a `start` pulse it identifies the target, prepares its configuration memory, waits for the erase to finish, streams the bitstream and then confirms that the target reports configuration complete. The outcome is given as a pass flag and an error code, both held until the next run.

Bitstream bytes enter on a valid/ready byte stream, and the byte count is taken from `bs_len` at the start pulse. `bs_ready` is raised only while the burst frame is waiting for its next payload byte. A byte moves on a clock edge where both `bs_valid` and `bs_ready` are high. The source may hold `bs_valid` low for as long as it needs. During that time chip select stays asserted and SCLK stays low, so the open frame simply pauses. `bs_data` must stay stable while `bs_valid` is high and `bs_ready` is low.

Every SPI frame uses mode 0 with the most significant bit first. A frame is one chip-select assertion, and chip select goes high for at least one SCLK period between frames. A command frame is the opcode byte followed by zero stuffing bytes. A 32-bit result is read from bytes 4 to 7 of an 8-byte frame, with byte 4 as the most significant byte.

Top module: `fpgacfg_spi_loader`

## Requirements
- R1: A start pulse with `bs_len` equal to zero ends the run at once with `err_code` = 1 and `done_ok` = 0. No chip-select assertion and no SCLK edge occur.
- R2: SPI timing is mode 0, MSB first: SCLK idles low, MOSI does not change at a rising SCLK edge, and MISO is sampled on the rising edge. Chip select is held low for a whole frame and stays high for at least 2*CLK_DIV clocks between frames. SCLK is low whenever chip select is high.
- R3: The first frame is an 8-byte ID read with opcode 0x07 and seven zero bytes. If the returned word is neither 0xC2088080 nor 0xC2048080, the run ends with `err_code` = 2 and no further frame is sent.
- R4: After a matching ID, the block sends an 8-byte status read (opcode 0x09). It then sends three 4-byte frames, each with three zero stuffing bytes, in this fixed order: 0x71, 0x4A, 0x70.
- R5: After the 0x70 frame, the status is polled with 8-byte 0x09 reads. Consecutive polls start at least POLL_CYCLES clocks apart. Polling stops with success only when the whole word equals 0x00010000.
- R6: If MAX_POLLS polls all return some other word, the run ends with `err_code` = 3 and no burst frame is sent.
- R7: The burst is a single frame of `bs_len`+8 bytes: 0x41, 0xFF, 0xFF, 0xFF, then the payload bytes in stream order, then four 0x00 bytes.
- R8: `bs_ready` is high only while the burst waits for a payload byte. While `bs_valid` is low at that point, chip select stays low and SCLK stays low.
- R9: After the burst, the block sends a 4-byte 0x4F frame and then one 8-byte status read. `done_ok` = 1 with `err_code` = 0 if bit 14 (mask 0x00004000) of that word is set; otherwise `err_code` = 4.
- R10: A start pulse while `busy` is high is ignored. The burst length and the result of the running job do not change.
- R11: `busy` is low after reset and goes high on the clock after an accepted nonzero-length start. It stays high until the result is posted. `done_ok` and `err_code` are 0 after reset and keep their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a configuration run |
| bs_len | input | LEN_W | Payload byte count, sampled at start |
| bs_valid | input | 1 | Payload byte available |
| bs_data | input | 8 | Payload byte |
| bs_ready | output | 1 | Burst frame accepts a payload byte |
| sclk | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the target |
| miso | input | 1 | SPI data from the target |
| busy | output | 1 | A run is in progress |
| done_ok | output | 1 | Last run configured the target |
| err_code | output | 3 | 0 none, 1 zero length, 2 unknown ID, 3 clear timeout, 4 DONE bit clear |

## Verification
The assertions assume that `start` is a single-cycle pulse and that `bs_data` holds still while a byte is offered and not yet taken. They also assume that `miso` changes only while SCLK is low, as a mode-0 slave drives it. The bench's target model updates MISO on falling SCLK edges and at chip-select assertion. The stream source changes `bs_valid` and `bs_data` only on falling system-clock edges, and it removes a byte only after a completed handshake.

// File: rtl/fcfg_pkg.sv
package fcfg_pkg;
  typedef enum logic [3:0] {
    ST_ID, ST_STAT0, ST_REFRESH, ST_WEN, ST_CLEAR,
    ST_POLL, ST_BURST, ST_WDIS, ST_STATF
  } step_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SEND, PH_SHIFT, PH_GAP, PH_WAIT
  } phase_t;

  localparam logic [2:0] ERR_NONE = 3'd0;
  localparam logic [2:0] ERR_LEN  = 3'd1;
  localparam logic [2:0] ERR_ID   = 3'd2;
  localparam logic [2:0] ERR_TMO  = 3'd3;
  localparam logic [2:0] ERR_DONE = 3'd4;

  localparam logic [31:0] TARGET_ID_A = 32'hC208_8080;
  localparam logic [31:0] TARGET_ID_B = 32'hC204_8080;
  localparam logic [31:0] WORD_ERASED = 32'h0001_0000;
  localparam logic [31:0] MASK_DONE   = 32'h0000_4000;

  function automatic logic [7:0] opcode_of(step_t s);
    case (s)
      ST_ID:      return 8'h07;
      ST_REFRESH: return 8'h71;
      ST_WEN:     return 8'h4A;
      ST_CLEAR:   return 8'h70;
      ST_BURST:   return 8'h41;
      ST_WDIS:    return 8'h4F;
      default:    return 8'h09;
    endcase
  endfunction

  function automatic logic is_read(step_t s);
    return (s == ST_ID) || (s == ST_STAT0) || (s == ST_POLL) || (s == ST_STATF);
  endfunction
endpackage

// File: rtl/fcfg_spi_byte.sv
module fcfg_spi_byte #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx,
  output logic       done
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

  logic          active;
  logic [DW-1:0] div_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    sh;

  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      sh      <= '0;
      rx      <= '0;
      sclk    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !active) begin
        active  <= 1'b1;
        sh      <= tx;
        sclk    <= 1'b0;
        div_cnt <= '0;
        bit_cnt <= '0;
      end else if (active) begin
        if (div_cnt == DIV_LAST) begin
          div_cnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bit_cnt == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              sh      <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          div_cnt <= div_cnt + DW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fcfg_wait_timer.sv
module fcfg_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= val;
    else if (cnt != '0) cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/fpgacfg_spi_loader.sv
module fpgacfg_spi_loader
  import fcfg_pkg::*;
#(
  parameter int CLK_DIV     = 2,
  parameter int LEN_W       = 16,
  parameter int POLL_CYCLES = 500000,
  parameter int MAX_POLLS   = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] bs_len,
  input  logic             bs_valid,
  input  logic [7:0]       bs_data,
  output logic             bs_ready,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic             busy,
  output logic             done_ok,
  output logic [2:0]       err_code
);
  localparam int IW      = LEN_W + 1;
  localparam int GAP_CYC = 2 * CLK_DIV;
  localparam int TMAX    = (POLL_CYCLES > GAP_CYC) ? POLL_CYCLES : GAP_CYC;
  localparam int TW      = $clog2(TMAX + 1);
  localparam int PW      = $clog2(MAX_POLLS + 1);

  phase_t           phase;
  step_t            step;
  logic [IW-1:0]    idx, flen, len_q;
  logic [31:0]      word;
  logic [PW-1:0]    polls;
  logic [7:0]       tx_byte, rx_byte;
  logic             eng_go, eng_done, payload_ph, last_byte;
  logic             tmr_zero, load_gap, load_poll, tmr_load, poll_miss;
  logic [TW-1:0]    tmr_val;

  always_comb begin
    payload_ph = (step == ST_BURST) && (idx >= IW'(4)) && (idx < len_q + IW'(4));
    if (step == ST_BURST)      flen = len_q + IW'(8);
    else if (is_read(step))    flen = IW'(8);
    else                       flen = IW'(4);
    if (idx == '0)             tx_byte = opcode_of(step);
    else if (step == ST_BURST && idx < IW'(4)) tx_byte = 8'hFF;
    else if (payload_ph)       tx_byte = bs_data;
    else                       tx_byte = 8'h00;
  end

  assign bs_ready  = (phase == PH_SEND) && payload_ph;
  assign eng_go    = (phase == PH_SEND) && (!payload_ph || bs_valid);
  assign last_byte = (idx == flen - IW'(1));
  assign poll_miss = (word != WORD_ERASED);
  assign load_gap  = (phase == PH_SHIFT) && eng_done && last_byte;
  assign load_poll = (phase == PH_GAP) && tmr_zero && (step == ST_POLL) && poll_miss
                     && (polls != PW'(MAX_POLLS - 1));
  assign tmr_load  = load_gap || load_poll;
  assign tmr_val   = load_poll ? TW'(POLL_CYCLES) : TW'(GAP_CYC);
  assign busy      = (phase != PH_IDLE);

  fcfg_spi_byte #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(eng_go), .tx(tx_byte), .miso(miso),
    .sclk(sclk), .mosi(mosi), .rx(rx_byte), .done(eng_done)
  );

  fcfg_wait_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      step     <= ST_ID;
      idx      <= '0;
      len_q    <= '0;
      word     <= '0;
      polls    <= '0;
      cs_n     <= 1'b1;
      done_ok  <= 1'b0;
      err_code <= ERR_NONE;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          done_ok <= 1'b0;
          if (bs_len == '0) begin
            err_code <= ERR_LEN;
          end else begin
            err_code <= ERR_NONE;
            len_q    <= {1'b0, bs_len};
            step     <= ST_ID;
            idx      <= '0;
            cs_n     <= 1'b0;
            phase    <= PH_SEND;
          end
        end
        PH_SEND: if (eng_go) phase <= PH_SHIFT;
        PH_SHIFT: if (eng_done) begin
          word <= {word[23:0], rx_byte};
          if (last_byte) begin
            cs_n  <= 1'b1;
            phase <= PH_GAP;
          end else begin
            idx   <= idx + IW'(1);
            phase <= PH_SEND;
          end
        end
        PH_GAP: if (tmr_zero) begin
          idx   <= '0;
          cs_n  <= 1'b0;
          phase <= PH_SEND;
          case (step)
            ST_ID:
              if (word == TARGET_ID_A || word == TARGET_ID_B) step <= ST_STAT0;
              else begin
                cs_n <= 1'b1; err_code <= ERR_ID; phase <= PH_IDLE;
              end
            ST_STAT0:   step <= ST_REFRESH;
            ST_REFRESH: step <= ST_WEN;
            ST_WEN:     step <= ST_CLEAR;
            ST_CLEAR: begin
              step  <= ST_POLL;
              polls <= '0;
            end
            ST_POLL:
              if (!poll_miss) step <= ST_BURST;
              else if (polls == PW'(MAX_POLLS - 1)) begin
                cs_n <= 1'b1; err_code <= ERR_TMO; phase <= PH_IDLE;
              end else begin
                polls <= polls + PW'(1);
                cs_n  <= 1'b1;
                phase <= PH_WAIT;
              end
            ST_BURST:   step <= ST_WDIS;
            ST_WDIS:    step <= ST_STATF;
            default: begin
              cs_n  <= 1'b1;
              phase <= PH_IDLE;
              if ((word & MASK_DONE) != '0) done_ok <= 1'b1;
              else err_code <= ERR_DONE;
            end
          endcase
        end
        PH_WAIT: if (tmr_zero) begin
          cs_n  <= 1'b0;
          phase <= PH_SEND;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fcfg_checker.sv
module fcfg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       bs_valid,
  input logic       bs_ready,
  input logic       sclk,
  input logic       cs_n,
  input logic       mosi,
  input logic       busy,
  input logic       done_ok,
  input logic [2:0] err_code
);
  a_r2_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  a_r2_mosi_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $rose(sclk)) |-> $stable(mosi));

  a_r8_ready_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bs_ready |-> (busy && !cs_n));

  a_r8_stall_pauses_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_ready && !bs_valid) |=> (!sclk && !cs_n));

  a_r9_pass_has_no_error: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> (err_code == 3'd0));

  a_r11_result_held_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && !$past(start)) |-> ($stable(err_code) && $stable(done_ok)));
endmodule

bind fpgacfg_spi_loader fcfg_checker u_fcfg_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .bs_valid(bs_valid), .bs_ready(bs_ready),
  .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy), .done_ok(done_ok),
  .err_code(err_code)
);

// File: tb/fpgacfg_spi_loader_test.sv
module fpgacfg_spi_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 2;
  localparam int LW    = 8;
  localparam int PCYC  = 60;
  localparam int MPOLL = 4;

  logic clk = 0, rst_n = 0, start = 0, bs_valid = 0, miso = 0;
  logic [LW-1:0] bs_len = '0;
  logic [7:0] bs_data = '0;
  logic bs_ready, sclk, cs_n, mosi, busy, done_ok;
  logic [2:0] err_code;

  fpgacfg_spi_loader #(.CLK_DIV(DIV), .LEN_W(LW), .POLL_CYCLES(PCYC), .MAX_POLLS(MPOLL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bs_len(bs_len), .bs_valid(bs_valid),
    .bs_data(bs_data), .bs_ready(bs_ready), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .busy(busy), .done_ok(done_ok), .err_code(err_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // target model
  logic [31:0] id_val, clr_val, fin_val, resp;
  int clear_after;
  bit clear_seen, wdis_seen;
  int poll_n, bc, bi;
  logic [7:0] shin, cur_op;
  logic [7:0] fb [0:63];
  logic [7:0] f_op [0:31];
  int f_len [0:31];
  int f_t0 [0:31];
  logic [7:0] burst [0:63];
  int burst_len, nf, cyc, hi_cnt, gap_bad, stuff_bad, sclk_rises;
  logic [7:0] pay [0:31];

  always @(posedge clk) begin
    cyc++;
    if (cs_n) hi_cnt++;
  end

  always @(negedge cs_n) begin
    if (nf > 0 && hi_cnt < 2*DIV) gap_bad++;
    bc = 0; bi = 0; miso = 0;
    if (nf < 32) f_t0[nf] = cyc;
  end

  always @(posedge sclk) begin
    sclk_rises++;
    shin = {shin[6:0], mosi};
    bi++;
    if (bi == 8) begin
      if (bc < 64) fb[bc] = shin;
      if (bc == 0) begin
        cur_op = shin;
        if (shin == 8'h07) resp = id_val;
        else if (shin == 8'h09) begin
          if (wdis_seen) resp = fin_val;
          else if (clear_seen) begin
            resp = (poll_n < clear_after) ? 32'h0 : clr_val;
            poll_n++;
          end else resp = 32'h0000_0000;
        end else resp = 32'h0;
      end
      bc++; bi = 0;
    end
  end

  always @(negedge sclk) begin
    if (bc >= 4 && bc < 8 && (cur_op == 8'h07 || cur_op == 8'h09))
      miso = resp[31 - ((bc - 4) * 8 + bi)];
    else miso = 0;
  end

  always @(posedge cs_n) begin
    if (nf < 32) begin
      f_op[nf] = fb[0];
      f_len[nf] = bc;
    end
    if (fb[0] == 8'h70) clear_seen = 1;
    if (fb[0] == 8'h4F) wdis_seen = 1;
    if (fb[0] == 8'h41) begin
      burst_len = bc;
      for (int k = 0; k < 64; k++) burst[k] = fb[k];
    end else begin
      for (int k = 1; k < 8; k++) if (k < bc && fb[k] != 8'h00) stuff_bad++;
    end
    nf++;
    hi_cnt = 0;
  end

  task automatic clear_log();
    nf = 0; gap_bad = 0; stuff_bad = 0; burst_len = 0; poll_n = 0;
    clear_seen = 0; wdis_seen = 0; sclk_rises = 0;
  endtask

  task automatic run(input int len, input logic [31:0] idv, input int clr_after,
                     input logic [31:0] clrv, input logic [31:0] finv,
                     input bit stall, input bit dbl);
    bit stalled = 0;
    int i = 0;
    clear_log();
    id_val = idv; clear_after = clr_after; clr_val = clrv; fin_val = finv;
    for (int k = 0; k < 32; k++) pay[k] = 8'(k * 37 + 5);
    @(negedge clk); bs_len = LW'(len); start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    if (dbl) begin
      repeat (30) @(negedge clk);
      bs_len = LW'(3); start = 1;
      @(negedge clk); start = 0;
      chk(busy == 1'b1, "R10 still busy after extra start", busy, 1);
    end
    while (i < len && busy) begin
      if (stall && i == 3 && !stalled) begin
        stalled = 1;
        bs_valid = 0;
        while (!bs_ready && busy) @(negedge clk);
        repeat (40) @(negedge clk);
        begin
          int r0 = sclk_rises;
          bit hold_ok = 1;
          for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (sclk || cs_n || !bs_ready) hold_ok = 0;
          end
          chk(hold_ok && sclk_rises == r0, "R8 frame paused during stall", sclk_rises - r0, 0);
        end
      end
      bs_valid = 1; bs_data = pay[i];
      while (!bs_ready && busy) @(negedge clk);
      @(negedge clk);
      i++;
    end
    bs_valid = 0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_prefix(input string tag);
    chk(f_op[0] == 8'h07 && f_len[0] == 8, {tag, " R3 id frame"}, {f_op[0], 24'(f_len[0])}, {8'h07, 24'd8});
    chk(f_op[1] == 8'h09 && f_len[1] == 8, {tag, " R4 status frame"}, f_op[1], 8'h09);
    chk(f_op[2] == 8'h71 && f_op[3] == 8'h4A && f_op[4] == 8'h70
        && f_len[2] == 4 && f_len[3] == 4 && f_len[4] == 4,
        {tag, " R4 refresh/wen/clear order"}, {f_op[2], f_op[3], f_op[4]}, 24'h714A70);
  endtask

  task automatic chk_common(input string tag);
    chk(stuff_bad == 0, {tag, " R4 zero stuffing"}, stuff_bad, 0);
    chk(gap_bad == 0, {tag, " R2 chip-select gap"}, gap_bad, 0);
  endtask

  task automatic t_reset();
    chk(busy == 0, "R11 reset busy", busy, 0);
    chk(cs_n == 1, "R2 reset cs_n", cs_n, 1);
    chk(sclk == 0, "R2 reset sclk", sclk, 0);
    chk(done_ok == 0 && err_code == 0, "R11 reset result", {done_ok, err_code}, 0);
  endtask

  task automatic t_zero_len();
    clear_log();
    @(negedge clk); bs_len = '0; start = 1;
    @(negedge clk); start = 0;
    chk(busy == 0, "R1 zero length not busy", busy, 0);
    repeat (20) @(negedge clk);
    chk(err_code == 3'd1 && done_ok == 0, "R1 zero length error", err_code, 1);
    chk(nf == 0 && sclk_rises == 0 && cs_n == 1, "R1 no SPI traffic", nf, 0);
  endtask

  task automatic t_pass(input logic [31:0] idv, input int len, input bit stall, input bit dbl, input string tag);
    bit pay_ok = 1;
    run(len, idv, 2, 32'h0001_0000, 32'h0000_4000, stall, dbl);
    chk_prefix(tag);
    chk(nf == 11, {tag, " R5 frame count"}, nf, 11);
    chk(f_op[5] == 8'h09 && f_op[6] == 8'h09 && f_op[7] == 8'h09 && f_len[7] == 8,
        {tag, " R5 three polls"}, {f_op[5], f_op[6], f_op[7]}, 24'h090909);
    chk(f_t0[6] - f_t0[5] >= PCYC && f_t0[7] - f_t0[6] >= PCYC,
        {tag, " R5 poll spacing"}, f_t0[6] - f_t0[5], PCYC);
    chk(burst_len == len + 8, {tag, " R7/R10 burst length"}, burst_len, len + 8);
    if (burst[0] != 8'h41 || burst[1] != 8'hFF || burst[2] != 8'hFF || burst[3] != 8'hFF) pay_ok = 0;
    for (int k = 0; k < len; k++) if (burst[4 + k] != pay[k]) pay_ok = 0;
    for (int k = 0; k < 4; k++) if (burst[4 + len + k] != 8'h00) pay_ok = 0;
    chk(pay_ok, {tag, " R7 burst contents"}, pay_ok, 1);
    chk(f_op[9] == 8'h4F && f_len[9] == 4 && f_op[10] == 8'h09 && f_len[10] == 8,
        {tag, " R9 tail frames"}, {f_op[9], f_op[10]}, 16'h4F09);
    chk(done_ok == 1 && err_code == 0, {tag, " R9 pass result"}, {done_ok, err_code}, 4'b1000);
    chk_common(tag);
  endtask

  task automatic t_bad_id();
    run(6, 32'hC208_8081, 0, 32'h0001_0000, 32'h0000_4000, 0, 0);
    chk(nf == 1 && f_op[0] == 8'h07, "R3 only id frame sent", nf, 1);
    chk(err_code == 3'd2 && done_ok == 0, "R3 unknown id error", err_code, 2);
  endtask

  task automatic t_timeout();
    run(6, 32'hC204_8080, 0, 32'h0001_0001, 32'h0000_4000, 0, 0);
    chk_prefix("tmo");
    chk(nf == 5 + MPOLL, "R6 poll count", nf, 5 + MPOLL);
    chk(burst_len == 0, "R6 no burst frame", burst_len, 0);
    chk(err_code == 3'd3 && done_ok == 0, "R6 timeout error", err_code, 3);
    chk_common("tmo");
  endtask

  task automatic t_done_missing();
    run(5, 32'hC208_8080, 0, 32'h0001_0000, 32'hFFFF_BFFF, 0, 0);
    chk(nf == 9 && f_op[8] == 8'h09, "R9 final status read", nf, 9);
    chk(err_code == 3'd4 && done_ok == 0, "R9 done bit clear error", err_code, 4);
    repeat (30) @(negedge clk);
    chk(err_code == 3'd4 && busy == 0, "R11 result held", err_code, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc = 0; hi_cnt = 100; bc = 0; bi = 0; shin = 0; cur_op = 0; resp = 0;
    id_val = 0; clr_val = 0; fin_val = 0; clear_after = 0;
    clear_log();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_zero_len();
    t_pass(32'hC208_8080, 10, 0, 0, "idA");
    t_pass(32'hC204_8080, 7, 1, 1, "idB_stall");
    t_bad_id();
    t_timeout();
    t_done_missing();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule